// File: doc/BRIEF.md
# Packed Seconds-Days Time Counter

This block is the timekeeping core of a small real-time clock. One 32-bit word holds the current time as four binary fields: seconds, minutes, hours and a free-running day count. There is no calendar. A one-hertz tick enable advances the word by one second, but only while the count enable is high. Each advance produces a set of single-cycle event strobes. These mark the second itself, the minute, hour and day rollovers, and two kinds of alarm match.

New time and alarm words arrive on a load port. A time word is staged first, and it replaces the running word on the next tick. This mirrors a counter that lives in the slow one-hertz domain. While a staged word is still waiting for its tick, a further time load is discarded. An alarm word takes effect on the next clock. The time-of-day alarm recurs every day, because it ignores the day field. The full-date alarm also needs the day count to match, so it can be set more than 24 hours ahead.

Top module: `rtc_time_core`

## Requirements
- R1: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day count in bits 31:17, and all fields read zero after reset.
- R2: The word advances by exactly one second on a clock where `tick_1hz` and `count_en` are both 1. It holds its value when `tick_1hz` is 0, and also on a tick with `count_en` at 0 (apart from a load commit).
- R3: On an advance, seconds at 59 wrap to 0 and increment minutes, and `ev_min` pulses.
- R4: On an advance where minutes also wrap after 59, hours increment and `ev_hour` pulses.
- R5: On an advance where hours also wrap after 23, the day count increments and `ev_day` pulses.
- R6: On an advance, a day count of 32767 wraps to 0 like any other day rollover, with no extra indication.
- R7: `ev_sec` is high for exactly one clock after each advance, in the same cycle that the new time word appears. All event strobes are low in the cycle after that when no new tick arrives.
- R8: A time load is staged and then commits on the next tick, whatever the value of `count_en`. The commit replaces all fields at once with the loaded word and raises no event strobe on that tick.
- R9: A time load that arrives while an earlier staged word has not yet committed is ignored.
- R10: An alarm load replaces the alarm word one clock later, independently of the tick, and leaves the time word unchanged.
- R11: `ev_alarm_tod` pulses on an advance whose new seconds, minutes and hours equal those fields of the alarm word, whatever the day field holds.
- R12: `ev_alarm_day` pulses only on an advance whose whole new word, day count included, equals the alarm word.
- R13: A seconds, minutes or hours field holding a value above its wrap limit goes to 0 on the next advance and carries into the next field, just as a field at its limit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| count_en | input | 1 | Prescaler enable; counting happens only while high |
| time_load | input | 1 | Request to stage a new time word |
| time_load_word | input | 32 | Packed time word to stage |
| alarm_load | input | 1 | Request to replace the alarm word |
| alarm_load_word | input | 32 | Packed alarm word |
| time_word | output | 32 | Current packed time |
| ev_sec | output | 1 | Second event strobe |
| ev_min | output | 1 | Minute rollover strobe |
| ev_hour | output | 1 | Hour rollover strobe |
| ev_day | output | 1 | 24-hour rollover strobe |
| ev_alarm_tod | output | 1 | Time-of-day alarm strobe |
| ev_alarm_day | output | 1 | Full-date alarm strobe |

## Verification
On every cycle, the assertions check how the strobes nest: minute implies second, hour implies minute, day implies hour, and a date match implies a time-of-day match. They also check that the time word never moves without a tick, that a minute event leaves the seconds at zero, that a time-of-day strobe agrees with the alarm word, and that a commit tick stays silent. The exact values cannot be shown by these properties and are left to the bench's sweeps. That covers the carry chain across hour, day and day-count wrap boundaries, the handling of out-of-range fields, the discarding of a second staged load, and alarm timing, all checked against arithmetic on total seconds.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 15;
  localparam int TOD_W  = SEC_W + MIN_W + HOUR_W;
  localparam int WORD_W = TOD_W + DAY_W;

  // Field order MSB to LSB sets the bit positions of the packed word.
  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } rtc_word_t;

  typedef struct packed {
    logic sec;
    logic min;
    logic hour;
    logic day;
    logic alarm_tod;
    logic alarm_day;
  } rtc_events_t;
endpackage

// File: rtl/rtc_reset_sync.sv
module rtc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_wrap_field.sv
module rtc_wrap_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic [W-1:0] cur,
  input  logic         carry_in,
  output logic [W-1:0] nxt,
  output logic         carry_out
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic at_end;
  // Values above the limit are treated as already at the limit.
  assign at_end = (cur >= LAST_V);

  always_comb begin
    nxt       = cur;
    carry_out = 1'b0;
    if (carry_in) begin
      if (at_end) begin
        nxt       = '0;
        carry_out = 1'b1;
      end else begin
        nxt = cur + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_load_stage.sv
module rtc_load_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] req_word,
  input  logic         tick,
  output logic [W-1:0] pend_word,
  output logic         commit
);
  logic         pend_q, pend_d;
  logic [W-1:0] word_q, word_d;

  assign commit    = tick & pend_q;
  assign pend_word = word_q;

  always_comb begin
    pend_d = pend_q;
    word_d = word_q;
    if (commit) begin
      pend_d = 1'b0;
    end else if (req && !pend_q) begin
      pend_d = 1'b1;
      word_d = req_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= pend_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int W     = 32,
  parameter int TOD_W = 17
) (
  input  logic [W-1:0] now_word,
  input  logic [W-1:0] alarm_word,
  output logic         tod_hit,
  output logic         full_hit
);
  assign tod_hit  = (now_word[TOD_W-1:0] == alarm_word[TOD_W-1:0]);
  assign full_hit = (now_word == alarm_word);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_time_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int MIN_LAST  = 59,
  parameter int HOUR_LAST = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              count_en,
  input  logic              time_load,
  input  logic [WORD_W-1:0] time_load_word,
  input  logic              alarm_load,
  input  logic [WORD_W-1:0] alarm_load_word,
  output logic [WORD_W-1:0] time_word,
  output logic              ev_sec,
  output logic              ev_min,
  output logic              ev_hour,
  output logic              ev_day,
  output logic              ev_alarm_tod,
  output logic              ev_alarm_day
);
  logic rst_n_s;

  rtc_reset_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rtc_word_t   cur_q, nxt_d, adv;
  rtc_events_t ev_q, ev_d;
  logic [WORD_W-1:0] alarm_q, alarm_d;
  logic [WORD_W-1:0] pend_word;
  logic commit, advance;
  logic c_sec, c_min, c_hour;
  logic tod_hit, full_hit;

  rtc_load_stage #(.W(WORD_W)) i_load (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req       (time_load),
    .req_word  (time_load_word),
    .tick      (tick_1hz),
    .pend_word (pend_word),
    .commit    (commit)
  );

  // Carry chain: seconds always see an increment request.
  rtc_wrap_field #(.W(SEC_W), .LAST(SEC_LAST)) i_sec (
    .cur (cur_q.sec), .carry_in (1'b1), .nxt (adv.sec), .carry_out (c_sec)
  );
  rtc_wrap_field #(.W(MIN_W), .LAST(MIN_LAST)) i_min (
    .cur (cur_q.min), .carry_in (c_sec), .nxt (adv.min), .carry_out (c_min)
  );
  rtc_wrap_field #(.W(HOUR_W), .LAST(HOUR_LAST)) i_hour (
    .cur (cur_q.hour), .carry_in (c_min), .nxt (adv.hour), .carry_out (c_hour)
  );
  // Day count wraps at its natural width with no flag.
  assign adv.day = cur_q.day + DAY_W'(c_hour);

  rtc_alarm_match #(.W(WORD_W), .TOD_W(TOD_W)) i_match (
    .now_word   (adv),
    .alarm_word (alarm_q),
    .tod_hit    (tod_hit),
    .full_hit   (full_hit)
  );

  assign advance = tick_1hz & count_en;

  always_comb begin
    nxt_d = cur_q;
    ev_d  = '0;
    if (commit) begin
      nxt_d = rtc_word_t'(pend_word);
    end else if (advance) begin
      nxt_d          = adv;
      ev_d.sec       = 1'b1;
      ev_d.min       = c_sec;
      ev_d.hour      = c_min;
      ev_d.day       = c_hour;
      ev_d.alarm_tod = tod_hit;
      ev_d.alarm_day = full_hit;
    end
  end

  always_comb begin
    alarm_d = alarm_q;
    if (alarm_load) alarm_d = alarm_load_word;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cur_q   <= '0;
      ev_q    <= '0;
      alarm_q <= '0;
    end else begin
      cur_q   <= nxt_d;
      ev_q    <= ev_d;
      alarm_q <= alarm_d;
    end
  end

  assign time_word    = cur_q;
  assign ev_sec       = ev_q.sec;
  assign ev_min       = ev_q.min;
  assign ev_hour      = ev_q.hour;
  assign ev_day       = ev_q.day;
  assign ev_alarm_tod = ev_q.alarm_tod;
  assign ev_alarm_day = ev_q.alarm_day;
endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk
  import rtc_time_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              count_en,
  input logic [WORD_W-1:0] time_word,
  input logic [WORD_W-1:0] alarm_word,
  input logic              commit,
  input logic              ev_sec,
  input logic              ev_min,
  input logic              ev_hour,
  input logic              ev_day,
  input logic              ev_alarm_tod,
  input logic              ev_alarm_day
);
  AST_MIN_NEEDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min |-> ev_sec); // R3
  AST_MIN_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min |-> (time_word[SEC_W-1:0] == '0)); // R3
  AST_HOUR_NEEDS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hour |-> ev_min); // R4
  AST_DAY_NEEDS_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |-> ev_hour); // R5
  AST_SEC_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec |-> ($past(tick_1hz) && $past(count_en))); // R2
  AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_1hz) |-> $stable(time_word)); // R2
  AST_COMMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> !ev_sec); // R8
  AST_TOD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm_tod |-> (time_word[TOD_W-1:0] == $past(alarm_word[TOD_W-1:0]))); // R11
  AST_DATE_NEEDS_TOD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm_day |-> ev_alarm_tod); // R12
endmodule

bind rtc_time_core rtc_time_core_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_1hz     (tick_1hz),
  .count_en     (count_en),
  .time_word    (time_word),
  .alarm_word   (alarm_q),
  .commit       (commit),
  .ev_sec       (ev_sec),
  .ev_min       (ev_min),
  .ev_hour      (ev_hour),
  .ev_day       (ev_day),
  .ev_alarm_tod (ev_alarm_tod),
  .ev_alarm_day (ev_alarm_day)
);

// File: tb/test_rtc_time_core.sv
module test_rtc_time_core;
  localparam longint DAY_S = 86400;
  localparam longint SPAN  = 64'd32768 * DAY_S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, count_en = 1'b0;
  logic time_load = 1'b0, alarm_load = 1'b0;
  logic [31:0] time_load_word = '0, alarm_load_word = '0;
  logic [31:0] time_word;
  logic ev_sec, ev_min, ev_hour, ev_day, ev_alarm_tod, ev_alarm_day;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  rtc_time_core i_rtc_time_core (
    .clk (clk), .rst_n (rst_n), .tick_1hz (tick_1hz), .count_en (count_en),
    .time_load (time_load), .time_load_word (time_load_word),
    .alarm_load (alarm_load), .alarm_load_word (alarm_load_word),
    .time_word (time_word), .ev_sec (ev_sec), .ev_min (ev_min),
    .ev_hour (ev_hour), .ev_day (ev_day),
    .ev_alarm_tod (ev_alarm_tod), .ev_alarm_day (ev_alarm_day)
  );

  function automatic logic [31:0] pack(longint t);
    longint d, r;
    logic [31:0] w;
    d = (t / DAY_S) % 32768;
    r = t % DAY_S;
    w = (32'(d) << 17) | (32'(r / 3600) << 12) | (32'((r % 3600) / 60) << 6) | 32'(r % 60);
    return w;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick_once(logic en);
    @(negedge clk); tick_1hz = 1'b1; count_en = en;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic load_time(logic [31:0] w);
    @(negedge clk); time_load = 1'b1; time_load_word = w;
    @(negedge clk); time_load = 1'b0;
  endtask

  task automatic load_alarm(logic [31:0] w);
    @(negedge clk); alarm_load = 1'b1; alarm_load_word = w;
    @(negedge clk); alarm_load = 1'b0;
  endtask

  function automatic logic [5:0] evs();
    return {ev_sec, ev_min, ev_hour, ev_day, ev_alarm_tod, ev_alarm_day};
  endfunction

  task automatic sweep(longint start, int n, longint alarm_t);
    longint t;
    load_alarm(pack(alarm_t));
    load_time(pack(start));
    tick_once(1'b1);
    check("R8", "commit word", time_word, pack(start));
    check("R8", "commit silent", 32'(evs()), 32'd0);
    t = start;
    for (int i = 0; i < n; i++) begin
      tick_once(1'b1);
      t = (t + 1) % SPAN;
      check("R2", "time", time_word, pack(t));
      check("R7", "ev_sec", 32'(ev_sec), 32'd1);
      check("R3", "ev_min", 32'(ev_min), 32'((t % 60) == 0));
      check("R4", "ev_hour", 32'(ev_hour), 32'((t % 3600) == 0));
      check("R5", "ev_day", 32'(ev_day), 32'((t % DAY_S) == 0));
      check("R11", "ev_alarm_tod", 32'(ev_alarm_tod), 32'((t % DAY_S) == (alarm_t % DAY_S)));
      check("R12", "ev_alarm_day", 32'(ev_alarm_day), 32'(t == alarm_t));
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "reset time", time_word, 32'd0);
    check("R7", "reset events", 32'(evs()), 32'd0);

    // R1: field positions built by shifts
    w = (32'd3 << 17) | (32'd5 << 12) | (32'd7 << 6) | 32'd9;
    load_time(w);
    tick_once(1'b0);
    check("R8", "commit with count_en low", time_word, w);
    tick_once(1'b1);
    check("R1", "sec field", 32'(time_word[5:0]), 32'd10);
    check("R1", "min field", 32'(time_word[11:6]), 32'd7);
    check("R1", "hour field", 32'(time_word[16:12]), 32'd5);
    check("R1", "day field", 32'(time_word[31:17]), 32'd3);
    @(negedge clk);
    check("R7", "pulse ends", 32'(evs()), 32'd0);

    // R2: no tick, and tick with count_en low
    repeat (5) @(negedge clk);
    check("R2", "hold without tick", time_word, w + 32'd1);
    tick_once(1'b0);
    check("R2", "hold with count_en low", time_word, w + 32'd1);
    check("R2", "no events when disabled", 32'(evs()), 32'd0);

    // R9: second load while staged is dropped
    load_time(pack(1000));
    load_time(pack(2000));
    tick_once(1'b1);
    check("R9", "first staged wins", time_word, pack(1000));
    tick_once(1'b1);
    check("R9", "second load gone", time_word, pack(1001));

    // R10: alarm load does not touch time
    load_alarm(pack(1002));
    check("R10", "time untouched", time_word, pack(1001));
    tick_once(1'b1);
    check("R10", "alarm live", 32'(ev_alarm_day), 32'd1);

    // R13: out-of-range fields
    load_time((32'd9 << 17) | (32'd23 << 12) | (32'd59 << 6) | 32'd62);
    tick_once(1'b1);
    tick_once(1'b1);
    check("R13", "sec 62 carries", time_word, 32'd10 << 17);
    check("R13", "carry events", 32'(evs()), 32'b111100);
    load_time((32'd1 << 17) | (32'd30 << 12) | (32'd61 << 6) | 32'd5);
    tick_once(1'b1);
    tick_once(1'b1);
    check("R13", "hour 30 and min 61 kept", time_word, (32'd1 << 17) | (32'd30 << 12) | (32'd61 << 6) | 32'd6);
    load_time((32'd1 << 17) | (32'd30 << 12) | (32'd61 << 6) | 32'd59);
    tick_once(1'b1);
    tick_once(1'b1);
    check("R13", "hour 30 wraps", time_word, 32'd2 << 17);

    // Sweeps: near zero, hour boundary, day wrap, distant alarms
    sweep(0, 130, 65);
    sweep(3 * DAY_S + 3540, 90, 5 * DAY_S + 3600);
    sweep(32767 * DAY_S + DAY_S - 70, 100, 32767 * DAY_S + DAY_S - 10);
    check("R6", "day count wrapped", 32'(time_word[31:17]), 32'd0);
    sweep(6 * DAY_S - 40, 80, 6 * DAY_S + 20);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule